// File: doc/BRIEF.md
# Isolated I/O Register Block with Change Interrupt

This block presents sixteen latched output lines and sixteen sampled input lines behind a byte-wide register bus made of a 3-bit address, a read strobe and a write strobe. Software sets and reads back the outputs eight lines at a time. It reads the synchronised inputs in two bytes. It can also read an interrupt status byte that records whether a change was seen on the lower or upper input byte.

Some registers act on the type of access and ignore the data. Reading the interrupt-control offset enables change interrupts, and writing it disables them. Writing the low input offset clears a pending interrupt. Reading the filter offset switches the input filter enables on, and writing it switches them off. Each input passes through a synchroniser, and then a change detector that responds to both edges. While interrupts are enabled, any change sets a sticky status bit. A level interrupt output stays high while a change is pending and interrupts are enabled.

Top module: `isolated_io_regs`

## Requirements
- R1: After reset, out_lines is 0, irq_out is 0, every filter_en bit is 1, bus_rvalid is 0 and the status byte reads 0.
- R2: A write to offset 0 loads out_lines[7:0] and a write to offset 4 loads out_lines[15:8] at that clock edge. A read of either offset returns the latched byte.
- R3: A read of offset 1 returns in_lines[7:0] and a read of offset 5 returns in_lines[15:8], both seen through a two-flop synchroniser.
- R4: A read of offset 2 enables interrupts. An input change then makes irq_out go high four clock edges after the change reaches in_lines.
- R5: A write to offset 2 disables interrupts. irq_out is low by the second edge after the write, and input changes made while interrupts are disabled are not recorded.
- R6: Both a rising edge and a falling edge on any input count as a change.
- R7: A write to offset 1, with any data, clears all status bits. irq_out is low by the second edge after the write. A clear takes priority over a change detected in the same cycle.
- R8: The status byte at offset 6 has bit 0 set for a change on inputs 0-7, bit 1 set for a change on inputs 8-15, and bit 2 set when either of them is set. All other bits read 0.
- R9: A read of offset 3 sets all filter_en bits to 1 and a write to offset 3 sets them to 0.
- R10: Writes to offsets 5, 6 and 7 change neither the outputs nor the status.
- R11: Read data and bus_rvalid appear one edge after the read strobe. Offsets 2, 3 and 7 read as 0. If bus_rd and bus_wr are high together, only the write takes effect and bus_rvalid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| in_lines | input | 16 | Asynchronous input lines |
| out_lines | output | 16 | Latched output lines |
| filter_en | output | 16 | Per-input filter enable |
| irq_out | output | 1 | Level interrupt request |

## Verification
A wrong enable or pending flag shows on irq_out within two edges of the access that should have changed it. A lost or stale change bit shows at the next read of the status byte. A wrong output latch shows on out_lines at the edge after the write, and at the next readback. A wrong synchroniser depth moves the time at which irq_out rises. The bench therefore checks irq_out at fixed cycle counts after each input change, and compares every read against a value queued from the requirements.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;
  typedef enum logic [2:0] {
    A_OUT_LO  = 3'd0,
    A_IN_LO   = 3'd1,
    A_IRQ_CTL = 3'd2,
    A_FILT    = 3'd3,
    A_OUT_HI  = 3'd4,
    A_IN_HI   = 3'd5,
    A_STAT    = 3'd6,
    A_SPARE   = 3'd7
  } reg_addr_e;

  localparam int ST_LO   = 0;
  localparam int ST_HI   = 1;
  localparam int ST_PEND = 2;
endpackage

// File: rtl/iso_io_outlat.sv
module iso_io_outlat #(
  parameter int BYTE_W = 8,
  parameter int NBANK  = 2,
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [BSEL_W-1:0]         wr_bank,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [NBANK*BYTE_W-1:0]   lines_q
);
  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst)
          lines_q[b*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && (wr_bank == BSEL_W'(b)))
          lines_q[b*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/iso_io_insync.sv
module iso_io_insync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dsync,
  output logic [WIDTH-1:0] changed
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  genvar s;
  generate
    for (s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= stg[STAGES-1];
  end

  // Either direction of transition counts as a change.
  assign dsync   = stg[STAGES-1];
  assign changed = stg[STAGES-1] ^ last_q;
endmodule

// File: rtl/iso_io_irq.sv
module iso_io_irq #(
  parameter int BYTE_W = 8,
  parameter int NBANK  = 2,
  localparam int LINES = BYTE_W * NBANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              ack,
  input  logic [LINES-1:0]  changed,
  output logic [BYTE_W-1:0] status,
  output logic              irq_q
);
  import iso_io_pkg::*;

  logic en_q, lo_q, hi_q;
  logic any_lo, any_hi;

  assign any_lo = |changed[BYTE_W-1:0];
  assign any_hi = |changed[LINES-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_clr)      en_q <= 1'b0;
      else if (en_set) en_q <= 1'b1;

      // Clear wins over a change seen in the same cycle.
      if (ack) begin
        lo_q <= 1'b0;
        hi_q <= 1'b0;
      end else if (en_q) begin
        lo_q <= lo_q | any_lo;
        hi_q <= hi_q | any_hi;
      end

      irq_q <= (lo_q | hi_q) & en_q;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_LO]   = lo_q;
    status[ST_HI]   = hi_q;
    status[ST_PEND] = lo_q | hi_q;
  end
endmodule

// File: rtl/isolated_io_regs.sv
module isolated_io_regs #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NBANK = 2,
  localparam int LINES = BYTE_W * NBANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [LINES-1:0]  in_lines,
  output logic [LINES-1:0]  out_lines,
  output logic [LINES-1:0]  filter_en,
  output logic              irq_out
);
  import iso_io_pkg::*;

  reg_addr_e        addr;
  logic             rd_go, wr_go;
  logic             out_wr, out_bank;
  logic [LINES-1:0] in_sync, in_chg;
  logic [BYTE_W-1:0] stat_byte;
  logic             filt_q;

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_go = bus_wr;
  assign rd_go = bus_rd & ~bus_wr;

  assign out_wr   = wr_go && (addr == A_OUT_LO || addr == A_OUT_HI);
  assign out_bank = (addr == A_OUT_HI);

  iso_io_outlat #(.BYTE_W(BYTE_W), .NBANK(NBANK)) u_outlat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (out_wr),
    .wr_bank (out_bank),
    .wr_data (bus_wdata),
    .lines_q (out_lines)
  );

  iso_io_insync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_insync (
    .clk     (clk),
    .rst     (rst),
    .din     (in_lines),
    .dsync   (in_sync),
    .changed (in_chg)
  );

  iso_io_irq #(.BYTE_W(BYTE_W), .NBANK(NBANK)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .en_set  (rd_go && addr == A_IRQ_CTL),
    .en_clr  (wr_go && addr == A_IRQ_CTL),
    .ack     (wr_go && addr == A_IN_LO),
    .changed (in_chg),
    .status  (stat_byte),
    .irq_q   (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                            filt_q <= 1'b1;
    else if (wr_go && addr == A_FILT)   filt_q <= 1'b0;
    else if (rd_go && addr == A_FILT)   filt_q <= 1'b1;
  end

  assign filter_en = {LINES{filt_q}};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) begin
        case (addr)
          A_OUT_LO: bus_rdata <= out_lines[BYTE_W-1:0];
          A_OUT_HI: bus_rdata <= out_lines[LINES-1:BYTE_W];
          A_IN_LO:  bus_rdata <= in_sync[BYTE_W-1:0];
          A_IN_HI:  bus_rdata <= in_sync[LINES-1:BYTE_W];
          A_STAT:   bus_rdata <= stat_byte;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/isolated_io_regs_chk.sv
module isolated_io_regs_chk #(
  parameter int BYTE_W = 8,
  parameter int LINES  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic [LINES-1:0]  out_lines,
  input logic [LINES-1:0]  filter_en,
  input logic              irq_out
);
  a_r2_low_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0) |=> out_lines[BYTE_W-1:0] == $past(bus_wdata));

  a_r2_high_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd4) |=> out_lines[LINES-1:BYTE_W] == $past(bus_wdata));

  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd4)) |=> $stable(out_lines));

  a_r5_disable_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd2) ##1 !(bus_rd && !bus_wr && bus_addr == 3'd2) |=> !irq_out);

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd1) ##1 1'b1 |=> !irq_out);

  a_r9_filter_off: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd3) |=> filter_en == '0);

  a_r9_filter_on: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == 3'd3) |=> filter_en == '1);

  a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_rvalid);
endmodule

bind isolated_io_regs isolated_io_regs_chk #(.BYTE_W(BYTE_W), .LINES(LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .out_lines  (out_lines),
  .filter_en  (filter_en),
  .irq_out    (irq_out)
);

// File: tb/isolated_io_regs_tb.sv
module isolated_io_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [15:0] in_lines = '0;
  logic [15:0] out_lines, filter_en;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  isolated_io_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .in_lines(in_lines), .out_lines(out_lines), .filter_en(filter_en), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every returned read against the queued expectation.
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0)
        check(1'b0, "R11 unexpected rvalid", 32'(bus_rdata), 32'hx);
      else begin
        exp_t it;
        it = exp_q.pop_front();
        check(bus_rdata == it.val, it.tag, 32'(bus_rdata), 32'(it.val));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check(out_lines == 16'h0, "R1 outputs", 32'(out_lines), 0);
    check(irq_out == 1'b0, "R1 irq", 32'(irq_out), 0);
    check(filter_en == 16'hFFFF, "R1 filter", 32'(filter_en), 32'hFFFF);
    check(bus_rvalid == 1'b0, "R1 rvalid", 32'(bus_rvalid), 0);
    bus_read(3'd6, 8'h00, "R1 status");

    // R2 output latches
    bus_write(3'd0, 8'hA5);
    bus_write(3'd4, 8'h3C);
    check(out_lines == 16'h3CA5, "R2 out_lines", 32'(out_lines), 32'h3CA5);
    bus_read(3'd0, 8'hA5, "R2 read low");
    bus_read(3'd4, 8'h3C, "R2 read high");

    // R3 input reads; R5 change while disabled is not recorded
    in_lines = 16'h1234;
    idle(4);
    bus_read(3'd1, 8'h34, "R3 in low");
    bus_read(3'd5, 8'h12, "R3 in high");
    bus_read(3'd6, 8'h00, "R5 no record while disabled");
    check(irq_out == 1'b0, "R5 irq while disabled", 32'(irq_out), 0);

    // R4 enable, rising edge on low byte; R11 offset 2 reads 0
    bus_read(3'd2, 8'h00, "R11 ctl reads zero");
    idle(2);
    in_lines = 16'h123C;
    idle(3);
    check(irq_out == 1'b0, "R4 irq not yet", 32'(irq_out), 0);
    idle(2);
    check(irq_out == 1'b1, "R4 irq raised", 32'(irq_out), 1);
    bus_read(3'd6, 8'h05, "R8 status low change");

    // R10 writes to 5, 6, 7 ignored
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'hFF);
    bus_write(3'd7, 8'hFF);
    check(out_lines == 16'h3CA5, "R10 outputs kept", 32'(out_lines), 32'h3CA5);
    bus_read(3'd6, 8'h05, "R10 status kept");

    // R7 clear
    bus_write(3'd1, 8'h00);
    idle(1);
    check(irq_out == 1'b0, "R7 irq cleared", 32'(irq_out), 0);
    bus_read(3'd6, 8'h00, "R7 status cleared");

    // R6 falling edge on high byte
    in_lines = 16'h023C;
    idle(6);
    check(irq_out == 1'b1, "R6 falling edge irq", 32'(irq_out), 1);
    bus_read(3'd6, 8'h06, "R8 status high change");

    // R5 disable with pending set
    bus_write(3'd2, 8'h00);
    idle(1);
    check(irq_out == 1'b0, "R5 irq drops", 32'(irq_out), 0);
    bus_write(3'd1, 8'h00);
    in_lines = 16'hFFFF;
    idle(6);
    bus_read(3'd2, 8'h00, "R4 re-enable");
    idle(4);
    check(irq_out == 1'b0, "R5 disabled changes lost", 32'(irq_out), 0);
    bus_read(3'd6, 8'h00, "R5 status empty");

    // R9 filter control
    bus_write(3'd3, 8'hFF);
    check(filter_en == 16'h0000, "R9 filter off", 32'(filter_en), 0);
    bus_read(3'd3, 8'h00, "R11 filter reads zero");
    check(filter_en == 16'hFFFF, "R9 filter on", 32'(filter_en), 32'hFFFF);

    // R11 read and write together: write only
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'h5A; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check(bus_rvalid == 1'b0, "R11 no rvalid", 32'(bus_rvalid), 0);
    check(out_lines == 16'h3C5A, "R11 write taken", 32'(out_lines), 32'h3C5A);

    idle(3);
    check(exp_q.size() == 0, "R11 all reads returned", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule